// File: doc/BRIEF.md
# System Control Register Block

This block is the 4 KB control and status window of a small two-core microcontroller subsystem. Software reaches it over a 32-bit simple peripheral bus. The block holds:

- a secure debug authorisation word;
- clock divider and clock force settings;
- the last reset cause and a reset mask;
- a retention word that survives warm resets;
- the boot vector table offset for each core;
- the hold-in-wait bits for the two cores;
- power-domain sense words.

It also returns a fixed set of identification bytes at the top of the window. The block stores values and raises pulses: a core-release pulse per core, a system software-reset request, and a one-cycle access error flag. The clocks, power sequencing and resets themselves are handled elsewhere.

A build-time version parameter selects the variant. When its top nibble is 2, the extended register set is present. Otherwise a base variant is built, and its extra locations behave as holes. There are two synchronous active-high resets. The power-on reset clears everything. The warm reset clears everything except the retention word.

Bus timing is fixed. An access happens when select and enable are both high. A write takes effect at the clock edge that ends that cycle. Read data is valid combinationally during that cycle. The release pulses, the reset request and the error flag go high during the single cycle that follows that edge.

Top module: `sysctl_regs`

## Requirements
- R1: The debug status word at 0x000 is read-only. A write at 0x004 ORs the written bits into it. A write at 0x008 clears every bit written as 1. Reads of 0x004 and 0x008 return zero.
- R2: The extended variant exists only when SYS_VERSION[31:28] is 2. In the base variant, the locations 0x00C–0x018, 0x114, 0x124, 0x200 and 0x20C–0x218 read zero, discard writes and flag an error.
- R3: Location 0x11C is read/write storage in the extended variant. In the base variant it reads zero without error, and a write to it is discarded and flagged as a write to a read-only location.
- R4: Writing 0x118 stores the new value. For each core n (n = 0, 1), bit n changing from 1 to 0 in that write raises core_release[n] for exactly the next cycle.
- R5: A write to 0x108 with bit 9 set raises sys_reset_req for the next cycle. Its other bits have no effect. Reads of 0x108 return zero and flag an error.
- R6: After either reset, the following values hold: 0x100 reads 1, 0x200 reads 0x7F (extended variant), 0x118 reads WAIT_RST, and 0x110/0x114 read VTOR0_RST/VTOR1_RST. Every other register reads 0.
- R7: The vtor0 and vtor1 outputs always carry the current contents of 0x110 and 0x114.
- R8: Locations 0xFD0–0xFFC read constant bytes: 04 00 00 00 54 B8 0B 00 0D F0 05 B1, in rising address order, in bits [7:0]. Writes to them are discarded.
- R9: The retention word at 0x10C is cleared only by por_rst. A warm_rst leaves it unchanged and clears all other state.
- R10: 0x100, 0x104, 0x120 and all the extended clock and power-sense words read back the last value written.
- R11: access_err goes high for the one cycle after any of these accesses: an access to an unmapped location, a read of a write-only location, or a write to a read-only location. It stays low after valid accesses.
- R12: Address bits [1:0] are ignored, and a read returns the full word. A write stores pwdata with every byte lane whose pstrb bit is 0 replaced by zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte lane strobes |
| prdata | output | 32 | Read data, valid in the access cycle |
| core_release | output | 2 | One-cycle release pulse per core |
| sys_reset_req | output | 1 | One-cycle software reset request |
| vtor0 | output | 32 | Boot vector offset for core 0 |
| vtor1 | output | 32 | Boot vector offset for core 1 |
| access_err | output | 1 | One-cycle illegal-access flag |

## Verification
Most internal faults appear on the next read of the affected location. Examples are a wrong lane mask, a lost set or clear bit, or a register cleared by the wrong reset. Such a fault shows up as a bad prdata value in the access cycle of that read. A faulty wait-bit comparison or decode shows up one cycle after the offending write, as a missing, extra or wrongly placed pulse on core_release, sys_reset_req or access_err. The pulse tests therefore also sample one cycle later to catch stretched pulses. A wrong variant decode is exposed by reading and writing the same holes on a base and an extended instance side by side.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW        = 32;
    localparam int AW        = 12;
    localparam int NCORE     = 2;
    localparam int NPLAIN    = 14;
    localparam int SWREQ_BIT = 9;
    localparam int IDBASE_W  = 10'h3F4;   // word index of the first ID location

    // Plain storage slots come first so that the slot number equals the id.
    typedef enum logic [4:0] {
        RID_SYND    = 5'd0,  RID_MASK   = 5'd1,  RID_WAKE   = 5'd2,
        RID_SECCTRL = 5'd3,  RID_FDIV   = 5'd4,  RID_SDIV   = 5'd5,
        RID_CLKF    = 5'd6,  RID_NMI    = 5'd7,  RID_EWCTRL = 5'd8,
        RID_PDSYS   = 5'd9,  RID_PDS0   = 5'd10, RID_PDS1   = 5'd11,
        RID_PDS2    = 5'd12, RID_PDS3   = 5'd13,
        RID_DBGSTAT = 5'd14, RID_DBGSET = 5'd15, RID_DBGCLR = 5'd16,
        RID_SWRST   = 5'd17, RID_RETAIN = 5'd18, RID_VTOR0  = 5'd19,
        RID_VTOR1   = 5'd20, RID_WAIT   = 5'd21, RID_ID     = 5'd22,
        RID_NONE    = 5'd23
    } rid_e;

    typedef struct packed {
        rid_e rid;
        logic rd_ok;
        logic wr_ok;
    } dec_t;

    function automatic logic is_ext(logic [31:0] ver);
        return ver[31:28] == 4'd2;
    endfunction

    function automatic dec_t mk(rid_e r, logic rd, logic wr);
        dec_t d;
        d.rid   = r;
        d.rd_ok = rd;
        d.wr_ok = wr;
        return d;
    endfunction

    // Decode a word index; ext selects the extended register set.
    function automatic dec_t decode(logic [AW-3:0] w, logic ext);
        dec_t d;
        d = mk(RID_NONE, 1'b0, 1'b0);
        case (w)
            10'h000: d = mk(RID_DBGSTAT, 1'b1, 1'b0);
            10'h001: d = mk(RID_DBGSET,  1'b0, 1'b1);
            10'h002: d = mk(RID_DBGCLR,  1'b0, 1'b1);
            10'h003: if (ext) d = mk(RID_SECCTRL, 1'b1, 1'b1);
            10'h004: if (ext) d = mk(RID_FDIV,    1'b1, 1'b1);
            10'h005: if (ext) d = mk(RID_SDIV,    1'b1, 1'b1);
            10'h006: if (ext) d = mk(RID_CLKF,    1'b1, 1'b1);
            10'h040: d = mk(RID_SYND,   1'b1, 1'b1);
            10'h041: d = mk(RID_MASK,   1'b1, 1'b1);
            10'h042: d = mk(RID_SWRST,  1'b0, 1'b1);
            10'h043: d = mk(RID_RETAIN, 1'b1, 1'b1);
            10'h044: d = mk(RID_VTOR0,  1'b1, 1'b1);
            10'h045: if (ext) d = mk(RID_VTOR1, 1'b1, 1'b1);
            10'h046: d = mk(RID_WAIT,   1'b1, 1'b1);
            10'h047: d = mk(RID_NMI,    1'b1, ext);
            10'h048: d = mk(RID_WAKE,   1'b1, 1'b1);
            10'h049: if (ext) d = mk(RID_EWCTRL, 1'b1, 1'b1);
            10'h080: if (ext) d = mk(RID_PDSYS,  1'b1, 1'b1);
            10'h083: if (ext) d = mk(RID_PDS0,   1'b1, 1'b1);
            10'h084: if (ext) d = mk(RID_PDS1,   1'b1, 1'b1);
            10'h085: if (ext) d = mk(RID_PDS2,   1'b1, 1'b1);
            10'h086: if (ext) d = mk(RID_PDS3,   1'b1, 1'b1);
            default: if (int'(w) >= IDBASE_W) d = mk(RID_ID, 1'b1, 1'b0);
        endcase
        return d;
    endfunction

    function automatic logic [DW-1:0] plain_rst(int slot);
        if (slot == int'(RID_SYND))  return 32'h1;
        if (slot == int'(RID_PDSYS)) return 32'h7F;
        return '0;
    endfunction

    function automatic logic [7:0] id_byte(logic [3:0] k);
        case (k)
            4'd0:  return 8'h04;
            4'd4:  return 8'h54;
            4'd5:  return 8'hB8;
            4'd6:  return 8'h0B;
            4'd8:  return 8'h0D;
            4'd9:  return 8'hF0;
            4'd10: return 8'h05;
            4'd11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [DW/8-1:0] s);
        logic [DW-1:0] m;
        for (int b = 0; b < DW/8; b++) m[b*8 +: 8] = {8{s[b]}};
        return m;
    endfunction

endpackage

// File: rtl/sysctl_plain_bank.sv
module sysctl_plain_bank
    import sysctl_pkg::*;
#(
    parameter int N = NPLAIN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         we,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0][DW-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic [DW-1:0] RV = plain_rst(i);

        always_ff @(posedge clk) begin
            if (rst)        q[i] <= RV;
            else if (we[i]) q[i] <= wdata;
        end

        p_hold_r10: assert property (@(posedge clk) disable iff (rst)
            !we[i] |=> $stable(q[i]));
    end

endmodule

// File: rtl/sysctl_keep.sv
module sysctl_keep
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          por_rst,
    input  logic          warm_rst,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic          ret_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dbg_q,
    output logic [DW-1:0] ret_q
);

    always_ff @(posedge clk) begin
        if (por_rst || warm_rst) dbg_q <= '0;
        else if (set_en)         dbg_q <= dbg_q | wdata;
        else if (clr_en)         dbg_q <= dbg_q & ~wdata;
    end

    // Retention word: only the power-on reset clears it.
    always_ff @(posedge clk) begin
        if (por_rst)     ret_q <= '0;
        else if (ret_en) ret_q <= wdata;
    end

    p_clear_bits_r1: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
        clr_en |=> ((dbg_q & $past(wdata)) == '0));

    p_warm_keeps_r9: assert property (@(posedge clk) disable iff (por_rst)
        (warm_rst && !ret_en) |=> $stable(ret_q));

endmodule

// File: rtl/sysctl_core_ctrl.sv
module sysctl_core_ctrl
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0]            WAIT_RST = '0,
    parameter logic [NCORE-1:0][DW-1:0] VTOR_RST = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wait_we,
    input  logic [NCORE-1:0]         vtor_we,
    input  logic                     swr_we,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            wait_q,
    output logic [NCORE-1:0][DW-1:0] vtor_q,
    output logic [NCORE-1:0]         release_o,
    output logic                     swreq_o
);

    always_ff @(posedge clk) begin
        if (rst)          wait_q <= WAIT_RST;
        else if (wait_we) wait_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) swreq_o <= 1'b0;
        else     swreq_o <= swr_we && wdata[SWREQ_BIT];
    end

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst)             vtor_q[i] <= VTOR_RST[i];
            else if (vtor_we[i]) vtor_q[i] <= wdata;
        end

        // Compare against the value held before this write.
        always_ff @(posedge clk) begin
            if (rst) release_o[i] <= 1'b0;
            else     release_o[i] <= wait_we && wait_q[i] && !wdata[i];
        end

        p_release_fall_r4: assert property (@(posedge clk) disable iff (rst)
            release_o[i] |-> ($past(wait_q[i]) && !wait_q[i]));
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] SYS_VERSION = 32'h2004_1743,
    parameter logic [31:0] WAIT_RST    = 32'h0,
    parameter logic [31:0] VTOR0_RST   = 32'h1000_0000,
    parameter logic [31:0] VTOR1_RST   = 32'h1000_0000
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        warm_rst,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    input  logic [3:0]  pstrb,
    output logic [31:0] prdata,
    output logic [1:0]  core_release,
    output logic        sys_reset_req,
    output logic [31:0] vtor0,
    output logic [31:0] vtor1,
    output logic        access_err
);

    localparam logic IS_EXT = is_ext(SYS_VERSION);
    localparam logic [NCORE-1:0][DW-1:0] VTOR_RST = {VTOR1_RST, VTOR0_RST};

    logic                      rst;
    logic                      access;
    logic                      wr_go;
    dec_t                      dec;
    logic [DW-1:0]             wval;
    logic [NPLAIN-1:0]         plain_we;
    logic [NPLAIN-1:0][DW-1:0] plain_q;
    logic [DW-1:0]             dbg_q, ret_q, wait_q;
    logic [NCORE-1:0][DW-1:0]  vtor_q;
    logic [NCORE-1:0]          vtor_we;
    logic [3:0]                slot;
    logic                      unused_addr_bits;

    assign rst              = por_rst || warm_rst;
    assign access           = psel && penable;
    assign dec              = decode(paddr[AW-1:2], IS_EXT);
    assign wval             = pwdata & lane_mask(pstrb);
    assign wr_go            = access && pwrite && dec.wr_ok;
    assign slot             = 4'(dec.rid);
    assign unused_addr_bits = ^paddr[1:0];

    for (genvar i = 0; i < NPLAIN; i++) begin : g_we
        assign plain_we[i] = wr_go && (int'(dec.rid) == i);
    end

    assign vtor_we[0] = wr_go && (dec.rid == RID_VTOR0);
    assign vtor_we[1] = wr_go && (dec.rid == RID_VTOR1);

    sysctl_plain_bank #(.N(NPLAIN)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (plain_we),
        .wdata (wval),
        .q     (plain_q)
    );

    sysctl_keep u_keep (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .set_en   (wr_go && (dec.rid == RID_DBGSET)),
        .clr_en   (wr_go && (dec.rid == RID_DBGCLR)),
        .ret_en   (wr_go && (dec.rid == RID_RETAIN)),
        .wdata    (wval),
        .dbg_q    (dbg_q),
        .ret_q    (ret_q)
    );

    sysctl_core_ctrl #(.WAIT_RST(WAIT_RST), .VTOR_RST(VTOR_RST)) u_cores (
        .clk       (clk),
        .rst       (rst),
        .wait_we   (wr_go && (dec.rid == RID_WAIT)),
        .vtor_we   (vtor_we),
        .swr_we    (wr_go && (dec.rid == RID_SWRST)),
        .wdata     (wval),
        .wait_q    (wait_q),
        .vtor_q    (vtor_q),
        .release_o (core_release),
        .swreq_o   (sys_reset_req)
    );

    always_comb begin
        prdata = '0;
        if (access && !pwrite && dec.rd_ok) begin
            case (dec.rid)
                RID_DBGSTAT: prdata = dbg_q;
                RID_RETAIN:  prdata = ret_q;
                RID_VTOR0:   prdata = vtor_q[0];
                RID_VTOR1:   prdata = vtor_q[1];
                RID_WAIT:    prdata = wait_q;
                RID_ID:      prdata = {24'h0, id_byte(paddr[5:2] - 4'd4)};
                default:     if (int'(dec.rid) < NPLAIN) prdata = plain_q[slot];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) access_err <= 1'b0;
        else     access_err <= access && (pwrite ? !dec.wr_ok : !dec.rd_ok);
    end

    assign vtor0 = vtor_q[0];
    assign vtor1 = vtor_q[1];

    p_swreq_cause_r5: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> $past(access && pwrite && paddr[11:2] == 10'h042
                                && pwdata[SWREQ_BIT] && pstrb[1]));

    p_base_gap_err_r2: assert property (@(posedge clk) disable iff (rst)
        (!IS_EXT && access && paddr[11:2] == 10'h004) |=> access_err);

    p_valid_noerr_r11: assert property (@(posedge clk) disable iff (rst)
        (access && !pwrite && paddr[11:2] == 10'h040) |=> !access_err);

    p_vtor_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (access && pwrite && paddr[11:2] == 10'h044 && pstrb == 4'hF)
            |=> vtor0 == $past(pwdata));

endmodule

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VT_RST     = 32'h1000_0000;
    localparam int          WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        por_rst, warm_rst;
    logic        psel_e, psel_b, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [3:0]  pstrb;
    logic [31:0] e_rd, b_rd, e_vt0, e_vt1, b_vt0, b_vt1;
    logic [1:0]  e_rel, b_rel;
    logic        e_swr, b_swr, e_err, b_err;

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [31:0] last_rd;
    logic        last_err, last_swr;
    logic [1:0]  last_rel;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regs dut_i (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst),
        .psel(psel_e), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .pstrb(pstrb), .prdata(e_rd), .core_release(e_rel),
        .sys_reset_req(e_swr), .vtor0(e_vt0), .vtor1(e_vt1), .access_err(e_err)
    );

    sysctl_regs #(.SYS_VERSION(32'h1000_0000), .WAIT_RST(32'h3)) dut_base_i (
        .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst),
        .psel(psel_b), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .pstrb(pstrb), .prdata(b_rd), .core_release(b_rel),
        .sys_reset_req(b_swr), .vtor0(b_vt0), .vtor1(b_vt1), .access_err(b_err)
    );

    function automatic logic [31:0] smask(logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    function automatic logic [31:0] id_exp(int k);
        case (k)
            0: return 32'h04;  4: return 32'h54;  5: return 32'hB8;
            6: return 32'h0B;  8: return 32'h0D;  9: return 32'hF0;
            10: return 32'h05; 11: return 32'hB1;
            default: return 32'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Setup cycle, access cycle, then sample registered outputs one cycle on.
    task automatic xfer(bit base, bit wr, logic [11:0] a, logic [31:0] d, logic [3:0] s);
        @(negedge clk);
        psel_e = !base; psel_b = base; penable = 1'b0;
        pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        #1 last_rd = base ? b_rd : e_rd;
        @(negedge clk);
        psel_e = 1'b0; psel_b = 1'b0; penable = 1'b0;
        last_err = base ? b_err : e_err;
        last_rel = base ? b_rel : e_rel;
        last_swr = base ? b_swr : e_swr;
    endtask

    task automatic wr(bit base, logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
        xfer(base, 1'b1, a, d, s);
    endtask

    task automatic rd(bit base, logic [11:0] a);
        xfer(base, 1'b0, a, 32'h0, 4'h0);
    endtask

    task automatic pulse_reset(bit por);
        @(negedge clk);
        if (por) por_rst = 1'b1; else warm_rst = 1'b1;
        repeat (2) @(negedge clk);
        por_rst = 1'b0; warm_rst = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected finish", WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] paddrs [14];
        logic [31:0] model  [14];
        logic [31:0] dbg_m, seed_v;
        por_rst = 1'b0; warm_rst = 1'b0; psel_e = 1'b0; psel_b = 1'b0;
        penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0; pstrb = '0;
        seed_v = $urandom(32'd20240611);
        paddrs = '{12'h00C, 12'h010, 12'h014, 12'h018, 12'h100, 12'h104, 12'h11C,
                   12'h120, 12'h124, 12'h200, 12'h20C, 12'h210, 12'h214, 12'h218};
        pulse_reset(1'b1);

        // R6 reset values
        rd(0, 12'h100); chk("R6 syndrome", last_rd, 32'h1);
        rd(0, 12'h200); chk("R6 sys sense", last_rd, 32'h7F);
        rd(0, 12'h110); chk("R6 vtor0 reg", last_rd, VT_RST);
        rd(0, 12'h114); chk("R6 vtor1 reg", last_rd, VT_RST);
        rd(0, 12'h118); chk("R6 wait ext", last_rd, 32'h0);
        rd(1, 12'h118); chk("R6 wait base param", last_rd, 32'h3);
        rd(0, 12'h000); chk("R6 debug", last_rd, 32'h0);
        chk("R6 vtor0 port", e_vt0, VT_RST);

        // R8 identification bytes
        for (int k = 0; k < 12; k++) begin
            rd(0, 12'hFD0 + 12'(4*k));
            chk("R8 id value", last_rd, id_exp(k));
            chk("R8 id no err", {31'h0, last_err}, 32'h0);
        end

        // R1 debug set/clear
        wr(0, 12'h004, 32'hA5);  rd(0, 12'h000); chk("R1 set", last_rd, 32'hA5);
        wr(0, 12'h008, 32'h21);  rd(0, 12'h000); chk("R1 clear", last_rd, 32'h84);
        wr(0, 12'h004, 32'h100); rd(0, 12'h000); chk("R1 set keeps", last_rd, 32'h184);
        rd(0, 12'h004); chk("R1 wo read zero", last_rd, 32'h0);
        chk("R11 wo read err", {31'h0, last_err}, 32'h1);

        // R10 random plain storage against model
        pulse_reset(1'b1);
        for (int i = 0; i < 14; i++) model[i] = 32'h0;
        model[4] = 32'h1; model[9] = 32'h7F;
        for (int n = 0; n < 40; n++) begin
            int          si, ri;
            logic [31:0] d;
            logic [3:0]  s;
            si = int'($urandom % 14); d = $urandom; s = 4'($urandom % 16);
            wr(0, paddrs[si], d, s);
            model[si] = d & smask(s);
            ri = int'($urandom % 14);
            rd(0, paddrs[ri] + 12'($urandom % 4));
            chk("R10 readback", last_rd, model[ri]);
        end

        // R1 random set/clear against model
        dbg_m = 32'h0;
        for (int n = 0; n < 20; n++) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom % 2 == 0) begin wr(0, 12'h004, d); dbg_m = dbg_m | d; end
            else                   begin wr(0, 12'h008, d); dbg_m = dbg_m & ~d; end
            rd(0, 12'h000); chk("R1 random", last_rd, dbg_m);
        end

        // R12 strobes and sub-word addresses
        wr(0, 12'h104, 32'hFFFF_FFFF, 4'b0010);
        rd(0, 12'h105); chk("R12 lane 1", last_rd, 32'h0000_FF00);
        wr(0, 12'h107, 32'h1234_5678, 4'b1001);
        rd(0, 12'h106); chk("R12 lanes 0,3", last_rd, 32'h1200_0078);

        // R4 core release
        wr(0, 12'h118, 32'h3); chk("R4 no pulse on set", {30'h0, last_rel}, 32'h0);
        wr(0, 12'h118, 32'h1); chk("R4 core1 pulse", {30'h0, last_rel}, 32'h2);
        @(negedge clk); chk("R4 one cycle", {30'h0, e_rel}, 32'h0);
        wr(0, 12'h118, 32'h0); chk("R4 core0 pulse", {30'h0, last_rel}, 32'h1);
        rd(0, 12'h118); chk("R4 stored", last_rd, 32'h0);
        wr(0, 12'h118, 32'h0); chk("R4 no pulse 0->0", {30'h0, last_rel}, 32'h0);
        wr(1, 12'h118, 32'h0); chk("R4 both base", {30'h0, last_rel}, 32'h3);

        // R5 software reset request
        wr(0, 12'h108, 32'h200); chk("R5 request", {31'h0, last_swr}, 32'h1);
        @(negedge clk); chk("R5 one cycle", {31'h0, e_swr}, 32'h0);
        wr(0, 12'h108, 32'hFFFF_FDFF); chk("R5 other bits", {31'h0, last_swr}, 32'h0);
        wr(0, 12'h108, 32'h200, 4'b0001); chk("R12 R5 lane off", {31'h0, last_swr}, 32'h0);
        rd(0, 12'h108); chk("R5 read zero", last_rd, 32'h0);
        chk("R5 read err", {31'h0, last_err}, 32'h1);

        // R7 vector offsets
        wr(0, 12'h114, 32'hDEAD_0040); chk("R7 vtor1", e_vt1, 32'hDEAD_0040);
        wr(0, 12'h110, 32'h0BAD_0080); chk("R7 vtor0", e_vt0, 32'h0BAD_0080);
        wr(1, 12'h114, 32'h5555_0000); chk("R2 base vtor1 err", {31'h0, last_err}, 32'h1);
        chk("R2 base vtor1 kept", b_vt1, VT_RST);

        // R2 variant holes
        wr(1, 12'h010, 32'h55); chk("R2 base write err", {31'h0, last_err}, 32'h1);
        rd(1, 12'h010); chk("R2 base read zero", last_rd, 32'h0);
        chk("R2 base read err", {31'h0, last_err}, 32'h1);
        rd(1, 12'h200); chk("R2 base sense zero", last_rd, 32'h0);
        wr(0, 12'h010, 32'h55); chk("R2 ext no err", {31'h0, last_err}, 32'h0);
        rd(0, 12'h010); chk("R2 ext storage", last_rd, 32'h55);

        // R3 location 0x11C
        wr(1, 12'h11C, 32'hF); chk("R3 base ro err", {31'h0, last_err}, 32'h1);
        rd(1, 12'h11C); chk("R3 base zero", last_rd, 32'h0);
        chk("R3 base read ok", {31'h0, last_err}, 32'h0);
        wr(0, 12'h11C, 32'hF); rd(0, 12'h11C); chk("R3 ext rw", last_rd, 32'hF);

        // R11 error flag
        wr(0, 12'h000, 32'hFF); chk("R11 ro write", {31'h0, last_err}, 32'h1);
        rd(0, 12'h000); chk("R11 ro unchanged", last_rd, dbg_m);
        wr(0, 12'hFE0, 32'hFF); chk("R11 id write", {31'h0, last_err}, 32'h1);
        rd(0, 12'hFE0); chk("R8 id unchanged", last_rd, 32'h54);
        rd(0, 12'h300); chk("R11 unmapped zero", last_rd, 32'h0);
        chk("R11 unmapped read", {31'h0, last_err}, 32'h1);
        wr(0, 12'h300, 32'h1); chk("R11 unmapped write", {31'h0, last_err}, 32'h1);
        wr(0, 12'h120, 32'h9); chk("R11 valid write", {31'h0, last_err}, 32'h0);

        // R9 retention across warm reset
        wr(0, 12'h10C, 32'hCAFE_F00D);
        wr(0, 12'h104, 32'h77);
        wr(0, 12'h004, 32'h3);
        pulse_reset(1'b0);
        rd(0, 12'h10C); chk("R9 retained", last_rd, 32'hCAFE_F00D);
        rd(0, 12'h104); chk("R9 mask cleared", last_rd, 32'h0);
        rd(0, 12'h000); chk("R9 debug cleared", last_rd, 32'h0);
        rd(0, 12'h110); chk("R9 vtor0 restored", last_rd, VT_RST);
        pulse_reset(1'b1);
        rd(0, 12'h10C); chk("R9 por clears", last_rd, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule